// File: doc/BRIEF.md
# ISDN Link Slave B-Channel Serial Port

This block is the data side of a serial link to an ISDN line controller. It is always a slave: the controller supplies a double-speed bit clock and a long frame sync pulse, and the port only listens to them. Each frame lasts 125 µs. It holds 192 bit clocks, which make 96 bit times, split into three 32-bit channels. Only the first 16 bit times of channel 0 are used. They carry the two B-channel octets, the first octet in the upper byte, and the port handles them together as one 16-bit word, most significant bit first. Channels 1 and 2, and the last half of channel 0, are ignored in both directions.

The host side sees two parallel handshakes. A one-cycle request pulse says that the transmit word has just been taken for the new frame, so the host may load the next one. A one-cycle valid pulse comes with each received word. If the host loads nothing, the last word is sent again. A loopback control routes the transmit bit internally to the receive sampler, so every word sent is received back.

The bit clock and frame sync are synchronised into the system clock, and their edges are found there. A state machine tracks the frame with four named transitions. T_FIRST goes from S_HUNT to S_BCHAN on the first frame start after reset. T_DONE goes from S_BCHAN to S_QUIET on the rising edge that opens bit time 16. T_NEXT goes from S_QUIET to S_BCHAN on the next frame start. T_RESYNC restarts S_BCHAN when a frame start arrives during the window.

Top module: `iom_bchan_port`

## Requirements
- R1: After reset the transmit enable, the request pulse and the valid pulse are all low.
- R2: Until the first frame start (state S_HUNT), the transmit enable stays low and no request or valid pulse occurs, whatever the bit clock and data do.
- R3: A frame start is a bit-clock rising edge at which frame sync is sampled high after being sampled low on the previous rising edge. At each frame start the held transmit word moves into the shifter, and the request pulse goes high for exactly one system clock.
- R4: The transmit enable is high for exactly bit times 0 to 15 of the frame. Each bit time spans two bit-clock periods and begins on a rising edge. In bit time k the transmit data carries bit 15-k of the word, so the first octet goes out most significant bit first, then the second octet. The data changes only at the start of a bit time.
- R5: From bit time 16 to the next frame start (channels 1 and 2 and the rest of channel 0), the transmit enable is low. It falls on a bit-clock rising edge.
- R6: The receive data is sampled on the second falling bit-clock edge of each bit time 0 to 15. The first bit sampled becomes bit 15 of the received word. After the 16th sample the valid pulse goes high for one system clock, and the word is presented with it.
- R7: Receive data outside bit times 0 to 15 has no effect on the received word.
- R8: If no transmit word is loaded during a frame, the next frame sends the same word again.
- R9: With loopback on, the received word equals the word transmitted in that frame, and the external receive pin is ignored.
- R10: A transmit word loaded while a frame is being sent does not change the bits of that frame. It is sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Double-speed bit clock from the line controller |
| fsync_i | input | 1 | Long frame sync pulse from the line controller |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit enable, low means the line is released |
| loop_en_i | input | 1 | Route transmit data internally to the receive sampler |
| tx_word_i | input | 16 | Next transmit word (first octet in bits 15:8) |
| tx_load_i | input | 1 | Load tx_word_i into the transmit holding register |
| tx_req_o | output | 1 | One-cycle pulse: held word taken, load the next |
| rx_word_o | output | 16 | Last received word (first octet in bits 15:8) |
| rx_valid_o | output | 1 | One-cycle pulse with a new received word |

## Verification
The word path is swept with a walking one through all 16 positions and with all-zero, all-one and alternating words. A wrong bit order, a swapped octet or a sample off by one bit time shows up as a specific wrong word, not just a difference. Noise is driven on the receive pin in channels 1 and 2 and in the second half of channel 0, so a window that is too long is caught. Frames with no load, or with a load inside the window, tell resend apart from clear-on-use and from early take-over. The loopback frames drive the inverted word on the external pin, so an ignored loopback control cannot match by accident.

// File: rtl/iom_pkg.sv
package iom_pkg;

    // Frame tracking states of the slot sequencer
    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,   // waiting for the first frame start
        S_BCHAN = 2'd1,   // inside the 16 B-channel bit times
        S_QUIET = 2'd2    // rest of the frame, line released
    } slot_state_e;

endpackage

// File: rtl/iom_edge_sync.sv
// Brings the external bit clock and frame sync into the system clock
// domain and flags the bit-clock edges.
module iom_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_lvl
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] bclk_pipe;
    logic [PIPE_W-1:0] fs_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_pipe <= '0;
            fs_pipe   <= '0;
        end else begin
            bclk_pipe <= {bclk_pipe[PIPE_W-2:0], bclk_i};
            fs_pipe   <= {fs_pipe[PIPE_W-2:0], fsync_i};
        end
    end

    assign bclk_rise = bclk_pipe[SYNC_STAGES-1] & ~bclk_pipe[SYNC_STAGES];
    assign bclk_fall = ~bclk_pipe[SYNC_STAGES-1] & bclk_pipe[SYNC_STAGES];
    assign fs_lvl    = fs_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/iom_slot_fsm.sv
// Frame sequencer: finds frame start and the B-channel window and issues
// the shift and sample strobes.
module iom_slot_fsm
    import iom_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CLK_PER_BIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_rise,
    input  logic        bclk_fall,
    input  logic        fs_lvl,
    output slot_state_e state,
    output logic        frame_start,
    output logic        shift_tick,
    output logic        sample_tick,
    output logic        word_done,
    output logic        win_oe,
    output logic        req_pulse
);
    localparam int RISES = WORD_W * CLK_PER_BIT;
    localparam int IDX_W = $clog2(RISES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RISES - 1);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(RISES);
    localparam logic [IDX_W-1:0] CPB      = IDX_W'(CLK_PER_BIT);

    slot_state_e      state_q, state_d;
    logic             fs_prev;
    logic [IDX_W-1:0] rise_idx;
    logic [IDX_W-1:0] next_idx;

    assign next_idx    = rise_idx + 1'b1;
    assign frame_start = bclk_rise & fs_lvl & ~fs_prev;

    // Frame sync is sampled on each bit-clock rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
        end else if (bclk_rise) begin
            fs_prev <= fs_lvl;
        end
    end

    // Rising-edge index inside the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_idx <= '0;
        end else if (frame_start) begin
            rise_idx <= '0;
        end else if (bclk_rise && state_q == S_BCHAN) begin
            rise_idx <= next_idx;
        end
    end

    // Next-state logic with the named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: begin
                if (frame_start) state_d = S_BCHAN;                 // T_FIRST
            end
            S_BCHAN: begin
                if (frame_start) state_d = S_BCHAN;                 // T_RESYNC
                else if (bclk_rise && next_idx == END_IDX)
                    state_d = S_QUIET;                              // T_DONE
            end
            S_QUIET: begin
                if (frame_start) state_d = S_BCHAN;                 // T_NEXT
            end
            default: state_d = S_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_oe    <= 1'b0;
            req_pulse <= 1'b0;
        end else begin
            win_oe    <= (state_d == S_BCHAN);
            req_pulse <= frame_start;
        end
    end

    // Strobes for the shifters
    always_comb begin
        shift_tick  = 1'b0;
        sample_tick = 1'b0;
        if (state_q == S_BCHAN && !frame_start) begin
            shift_tick = bclk_rise && (next_idx < END_IDX)
                         && ((next_idx % CPB) == '0);
        end
        if (state_q == S_BCHAN) begin
            sample_tick = bclk_fall && ((rise_idx % CPB) == (CPB - 1'b1));
        end
        word_done = sample_tick && (rise_idx == LAST_IDX);
    end

    assign state = state_q;

endmodule

// File: rtl/iom_tx_path.sv
// Transmit holding register and shifter, MSB first.
module iom_tx_path #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    input  logic              frame_start,
    input  logic              shift_tick,
    output logic              txd
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (tx_load) hold_q <= tx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sreg_q <= '0;
        else if (frame_start) sreg_q <= hold_q;
        else if (shift_tick)  sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
    end

    assign txd = sreg_q[WORD_W-1];

endmodule

// File: rtl/iom_rx_path.sv
// Receive shifter, MSB first, with word strobe.
module iom_rx_path #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              sample_tick,
    input  logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic [WORD_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sreg_q <= '0;
        else if (sample_tick) sreg_q <= {sreg_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= word_done;
            if (word_done) rx_word <= {sreg_q[WORD_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/iom_bchan_port.sv
// Slave B-channel serial port for an ISDN line controller link.
module iom_bchan_port
    import iom_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CLK_PER_BIT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              txd_oe_o,
    input  logic              loop_en_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              tx_load_i,
    output logic              tx_req_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    logic        bclk_rise;
    logic        bclk_fall;
    logic        fs_lvl;
    logic        frame_start;
    logic        shift_tick;
    logic        sample_tick;
    logic        word_done;
    logic        rx_bit;
    slot_state_e state;

    iom_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fsync_i   (fsync_i),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .fs_lvl    (fs_lvl)
    );

    iom_slot_fsm #(.WORD_W(WORD_W), .CLK_PER_BIT(CLK_PER_BIT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .fs_lvl      (fs_lvl),
        .state       (state),
        .frame_start (frame_start),
        .shift_tick  (shift_tick),
        .sample_tick (sample_tick),
        .word_done   (word_done),
        .win_oe      (txd_oe_o),
        .req_pulse   (tx_req_o)
    );

    iom_tx_path #(.WORD_W(WORD_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_word     (tx_word_i),
        .tx_load     (tx_load_i),
        .frame_start (frame_start),
        .shift_tick  (shift_tick),
        .txd         (txd_o)
    );

    // Internal loopback selects the transmit bit as receive source
    assign rx_bit = loop_en_i ? txd_o : rxd_i;

    iom_rx_path #(.WORD_W(WORD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (rx_bit),
        .sample_tick (sample_tick),
        .word_done   (word_done),
        .rx_word     (rx_word_o),
        .rx_valid    (rx_valid_o)
    );

endmodule

// File: rtl/iom_bchan_chk.sv
// Property checker attached to the port.
module iom_bchan_chk
    import iom_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input slot_state_e state,
    input logic        bclk_rise,
    input logic        txd_o,
    input logic        txd_oe_o,
    input logic        tx_req_o,
    input logic        rx_valid_o
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |=> !tx_req_o);                                     // R3

    AST_REQ_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> txd_oe_o);                                      // R3

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);                                 // R6

    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> txd_oe_o);                                    // R6

    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HUNT) |-> (!txd_oe_o && !tx_req_o && !rx_valid_o)); // R2

    AST_OE_FALLS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_oe_o) |-> $past(bclk_rise));                       // R5

    AST_TXD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_oe_o && $past(txd_oe_o) && !$past(bclk_rise)) |-> $stable(txd_o)); // R4

endmodule

bind iom_bchan_port iom_bchan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .bclk_rise  (bclk_rise),
    .txd_o      (txd_o),
    .txd_oe_o   (txd_oe_o),
    .tx_req_o   (tx_req_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sim_iom_bchan_port.sv
`timescale 1ns/1ps
module sim_iom_bchan_port;
    localparam int W = 16;
    localparam int HALF = 5;           // system clocks per bit-clock half period
    localparam int RISES_PER_FRAME = 192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         fsync = 1'b0;
    logic         rxd = 1'b1;
    logic         loop_en = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_load = 1'b0;
    logic         txd, txd_oe, tx_req, rx_valid;
    logic [W-1:0] rx_word;

    int n_checks = 0;
    int n_fail = 0;
    int req_total = 0;
    int rx_total = 0;
    logic [W-1:0] rx_last = '0;
    logic [W-1:0] hold_model = '0;

    always #4 clk = ~clk;

    iom_bchan_port u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk),
        .fsync_i    (fsync),
        .rxd_i      (rxd),
        .txd_o      (txd),
        .txd_oe_o   (txd_oe),
        .loop_en_i  (loop_en),
        .tx_word_i  (tx_word),
        .tx_load_i  (tx_load),
        .tx_req_o   (tx_req),
        .rx_word_o  (rx_word),
        .rx_valid_o (rx_valid)
    );

    // Pulse monitor: only counts and captures, bench computes deltas
    always @(posedge clk) begin
        if (tx_req) req_total <= req_total + 1;
        if (rx_valid) begin
            rx_total <= rx_total + 1;
            rx_last  <= rx_word;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [W-1:0] pat(input int i);
        case (i)
            16: pat = 16'h0000;
            17: pat = 16'hFFFF;
            18: pat = 16'hAAAA;
            19: pat = 16'h5555;
            default: pat = W'(1) << (i % W);
        endcase
    endfunction

    // One full frame of 192 bit clocks
    task automatic run_frame(input logic [W-1:0] rx_pat, input bit do_load,
                             input logic [W-1:0] next_word, input int load_at,
                             input bit loop);
        logic [W-1:0] tx_exp;
        int req0, rx0, bt;
        tx_exp = hold_model;
        req0 = req_total;
        rx0 = rx_total;
        for (int r = 0; r < RISES_PER_FRAME; r++) begin
            bt = r / 2;
            bclk  = 1'b1;
            fsync = (r < 4);
            if (r % 2 == 0) begin
                if (bt < W) rxd = loop ? ~tx_exp[W-1-bt] : rx_pat[W-1-bt];
                else        rxd = bt[0] ^ bt[2] ^ 1'b1;   // noise outside the window
            end
            if (do_load && r == load_at) begin
                tx_word = next_word;
                tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
                repeat (HALF - 1) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            if (r % 2 == 1) begin
                if (bt < W) begin
                    check("R4 oe in window", {31'd0, txd_oe}, 32'd1);
                    check("R4 tx bit", {31'd0, txd}, {31'd0, tx_exp[W-1-bt]});
                end else if (bt == 16 || bt == 40 || bt == 80) begin
                    check("R5 oe released", {31'd0, txd_oe}, 32'd0);
                end
            end
            @(negedge clk);
        end
        if (do_load) hold_model = next_word;
        check("R3 one request per frame", 32'(req_total - req0), 32'd1);
        check("R6 one word per frame", 32'(rx_total - rx0), 32'd1);
        if (loop) check("R9 loopback word", {16'd0, rx_last}, {16'd0, tx_exp});
        else      check("R6 R7 received word", {16'd0, rx_last}, {16'd0, rx_pat});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {31'd0, txd_oe}, 32'd0);
        check("R1 req", {31'd0, tx_req}, 32'd0);
        check("R1 valid", {31'd0, rx_valid}, 32'd0);

        // R2 bit clock and data without frame sync
        for (int r = 0; r < 40; r++) begin
            bclk = 1'b1;
            rxd = r[1];
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
            repeat (HALF) @(negedge clk);
            if (r % 8 == 7) check("R2 oe in hunt", {31'd0, txd_oe}, 32'd0);
        end
        check("R2 no request", 32'(req_total), 32'd0);
        check("R2 no word", 32'(rx_total), 32'd0);

        // First word for the first frame
        tx_word = 16'hC3A5;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        hold_model = 16'hC3A5;

        // Walking one and fixed patterns; some loads inside the window (R10)
        for (int i = 0; i < 20; i++) begin
            run_frame(pat(i), 1'b1, pat(i) ^ 16'h3C5A, (i % 4 == 1) ? 6 : 100, 1'b0);
        end

        // R8 no load: same word resent twice
        run_frame(16'h1234, 1'b0, '0, 0, 1'b0);
        run_frame(16'hFEDC, 1'b0, '0, 0, 1'b0);

        // R9 loopback with inverted external data
        loop_en = 1'b1;
        run_frame(16'h0000, 1'b1, 16'h8001, 100, 1'b1);
        run_frame(16'h0000, 1'b1, 16'h7E18, 10, 1'b1);
        run_frame(16'h0000, 1'b1, 16'h0000, 100, 1'b1);
        loop_en = 1'b0;

        finish_run();
    end

endmodule